// File: doc/BRIEF.md
# Cell Polling Slave, Transmit Side

This block is the physical-layer end of a word-oriented cell bus in the transmit direction. It runs in one clock domain. A bus master polls the ports behind the slave by driving a 5-bit address. The slave answers on a cell-available line, two cycles after the address, with whether the addressed port has room for a whole cell. As an option it can drive four dedicated lines instead, one per port, each showing that port's room all the time.

When the master pulls the active-low enable down, the slave takes the port addressed in the cycle just before the fall. It then forwards each word to that port with a one-hot write strobe. The first word is flagged as start of cell. The slave counts a fixed number of words per cell and checks odd parity on every word. A parity failure gives a one-cycle pulse. It also keeps the error qualifier of the selected port raised until the cell's last word. A cell that opens without its start marker is reported and dropped. Port-to-address assignment is either sequential from zero or taken from a parameter table. Buffering and width conversion sit outside the block.

Top module: `cell_poll_slave`

## Requirements
- R1: In polled mode, `clav[0]` shows the room input of the port that matched the address driven two cycles earlier. An address that matches no port gives 0, and `clav[3:1]` stays 0.
- R2: In direct mode (`DIRECT_STAT`=1, legal only with at most four ports), `clav[i]` equals `room[i]` one cycle later for each port. Bits of `clav` with no port are 0, and the address has no effect.
- R3: With `CUSTOM_MAP`=0, port i answers to address i. With `CUSTOM_MAP`=1, port i answers to `PORT_MAP[5*i+4:5*i]`. An unmatched address writes to no port.
- R4: The port of a cell is the one addressed in the cycle before `enb_n` falls. Address changes and further enable falls do not move it until `CELL_WORDS` words are done. A cell that follows with `enb_n` held low reuses that port.
- R5: A word is taken on each edge where `enb_n` is low, and its outputs appear after that edge. Bit p of `wr_en` is set for the selected port and `port_data` holds the word. The word is the first of a cell when `soc_in` is 1 and no cell is open; bit p of `port_soc` is set only on that word.
- R6: If `enb_n` is low while no cell is open and `soc_in` is 0, `soc_err` pulses for one cycle and no strobe is raised. A word with `soc_in` high that follows opens a cell normally.
- R7: Each taken word whose data plus `prty` bit carries an even count of ones raises `prty_err` for exactly the cycle after that word. A word with an odd count leaves it low.
- R8: From the word with bad parity through the last word of that cell, bit p of `port_err` is set with the strobe. The next cell starts with it clear.
- R9: A cycle with `enb_n` high inside a cell writes nothing and does not advance the word count.
- R10: Reset is synchronous and active low. During and just after reset, `clav`, `wr_en`, `port_soc`, `port_err`, `soc_err` and `prty_err` are 0 and no cell is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enb_n | input | 1 | Transfer enable from the master, active low |
| addr | input | 5 | Poll and select address |
| data | input | DW | Word from the master |
| prty | input | 1 | Odd parity bit covering `data` |
| soc_in | input | 1 | Start-of-cell marker on the first word |
| room | input | NPORTS | Per-port indication that a whole cell fits |
| clav | output | 4 | Cell-available answer (bit 0 polled, bits 0..3 direct) |
| wr_en | output | NPORTS | One-hot write strobe to the selected port |
| port_data | output | DW | Word forwarded to the ports |
| port_soc | output | NPORTS | Start-of-cell qualifier per port |
| port_err | output | NPORTS | Error qualifier per port, held to end of cell |
| soc_err | output | 1 | One-cycle pulse for a cell opened without its marker |
| prty_err | output | 1 | One-cycle pulse per word with a parity mismatch |

## Verification
The poll answer is tried over a table of addresses and room patterns. Each address is replaced by an unmatched one one cycle later, so a single-stage answer shows up as a wrong value. Cells are sent fresh, back to back with the enable held low, with a pause in the middle, and with the address changed during the cell. Together these separate a latched port from a live decode, and a word count that stops at the cell length from one that drifts. A parity fault placed mid-cell shows whether the pulse and the held qualifier start on the right word and clear for the next cell. A second instance with a custom address table and direct status lines checks the mapping and the per-port status lines.

// File: rtl/cps_pkg.sv
package cps_pkg;
   localparam int ADDR_W    = 5;
   localparam int MAX_PORTS = 31;
   localparam int CLAV_W    = 4;

   // default custom table: port i answers to address 30-i
   function automatic logic [MAX_PORTS*ADDR_W-1:0] descending_map();
      logic [MAX_PORTS*ADDR_W-1:0] m;
      m = '0;
      for (int i = 0; i < MAX_PORTS; i++)
         m[i*ADDR_W +: ADDR_W] = ADDR_W'(MAX_PORTS - 1 - i);
      return m;
   endfunction
endpackage

// File: rtl/cps_addr_map.sv
module cps_addr_map #(
   parameter int NPORTS     = 4,
   parameter int CUSTOM_MAP = 0,
   parameter logic [cps_pkg::MAX_PORTS*cps_pkg::ADDR_W-1:0] PORT_MAP = cps_pkg::descending_map(),
   parameter int PW         = 2
) (
   input  logic [cps_pkg::ADDR_W-1:0] addr,
   output logic                       hit,
   output logic [PW-1:0]              port
);
   import cps_pkg::*;

   logic [ADDR_W-1:0] tab [NPORTS];

   for (genvar i = 0; i < NPORTS; i++) begin : g_tab
      if (CUSTOM_MAP != 0) begin : g_custom
         assign tab[i] = PORT_MAP[i*ADDR_W +: ADDR_W];
      end else begin : g_direct
         assign tab[i] = ADDR_W'(i);
      end
   end

   if (NPORTS == 1) begin : g_single
      logic unused_addr;
      assign unused_addr = ^{addr, tab[0]};
      assign hit  = 1'b1;
      assign port = '0;
   end else begin : g_multi
      always_comb begin
         hit  = 1'b0;
         port = '0;
         for (int i = 0; i < NPORTS; i++) begin
            if (!hit && tab[i] == addr) begin
               hit  = 1'b1;
               port = PW'(i);
            end
         end
      end
   end
endmodule

// File: rtl/cps_status.sv
module cps_status #(
   parameter int NPORTS      = 4,
   parameter int DIRECT_STAT = 0,
   parameter int PW          = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       hit,
   input  logic [PW-1:0]              port,
   input  logic [NPORTS-1:0]          room,
   output logic [cps_pkg::CLAV_W-1:0] clav
);
   import cps_pkg::*;

   if (DIRECT_STAT != 0) begin : g_direct
      logic [CLAV_W-1:0] room_pad;
      logic              unused_sel;
      assign unused_sel = ^{hit, port};
      always_comb begin
         room_pad = '0;
         for (int i = 0; i < NPORTS; i++) room_pad[i] = room[i];
      end
      always_ff @(posedge clk) begin
         if (!rst_n) clav <= '0;
         else        clav <= room_pad;
      end
   end else begin : g_polled
      logic st;
      always_comb begin
         st = 1'b0;
         for (int i = 0; i < NPORTS; i++)
            if (hit && port == PW'(i)) st = room[i];
      end
      always_ff @(posedge clk) begin
         if (!rst_n) clav <= '0;
         else        clav <= {{(CLAV_W-1){1'b0}}, st};
      end

      AST_CLAV_UPPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         clav[CLAV_W-1:1] == '0);   // R1
   end
endmodule

// File: rtl/cps_parity.sv
module cps_parity #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enb_n,
   input  logic [DW-1:0] data,
   input  logic          prty,
   output logic          bad_now,
   output logic          prty_err
);
   // odd parity: data plus parity bit must hold an odd count of ones
   assign bad_now = !enb_n && !(^{data, prty});

   always_ff @(posedge clk) begin
      if (!rst_n) prty_err <= 1'b0;
      else        prty_err <= bad_now;
   end

   AST_PERR_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      prty_err |-> !$past(enb_n));   // R7
endmodule

// File: rtl/cps_xfer.sv
module cps_xfer #(
   parameter int NPORTS     = 4,
   parameter int DW         = 32,
   parameter int CELL_WORDS = 13,
   parameter int PW         = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enb_n,
   input  logic              soc_in,
   input  logic [DW-1:0]     data,
   input  logic              map_hit,
   input  logic [PW-1:0]     map_port,
   input  logic              bad_now,
   output logic [NPORTS-1:0] wr_en,
   output logic [NPORTS-1:0] port_soc,
   output logic [NPORTS-1:0] port_err,
   output logic [DW-1:0]     port_data,
   output logic              soc_err
);
   localparam int CW = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1;

   logic          enb_q, active, err_hold, sel_hit;
   logic [PW-1:0] sel_port;
   logic [CW-1:0] cnt;

   logic              fall, word_go, last, use_hit, err_word;
   logic [PW-1:0]     use_port;
   logic [NPORTS-1:0] onehot;

   always_comb begin
      fall     = enb_q && !enb_n;
      word_go  = !enb_n && (active || soc_in);
      last     = active ? (cnt == CW'(CELL_WORDS - 1)) : (CELL_WORDS == 1);
      use_port = (!active && fall) ? map_port : sel_port;
      use_hit  = (!active && fall) ? map_hit  : sel_hit;
      onehot   = use_hit ? (NPORTS'(1) << use_port) : '0;
      err_word = bad_now || (active && err_hold);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enb_q     <= 1'b1;
         active    <= 1'b0;
         err_hold  <= 1'b0;
         sel_hit   <= 1'b0;
         sel_port  <= '0;
         cnt       <= '0;
         wr_en     <= '0;
         port_soc  <= '0;
         port_err  <= '0;
         port_data <= '0;
         soc_err   <= 1'b0;
      end else begin
         enb_q    <= enb_n;
         wr_en    <= '0;
         port_soc <= '0;
         port_err <= '0;
         soc_err  <= 1'b0;
         if (fall && !active) begin
            sel_port <= map_port;
            sel_hit  <= map_hit;
         end
         if (word_go) begin
            wr_en     <= onehot;
            port_data <= data;
            port_soc  <= active ? '0 : onehot;
            port_err  <= err_word ? onehot : '0;
            if (last) begin
               active   <= 1'b0;
               cnt      <= '0;
               err_hold <= 1'b0;
            end else begin
               active   <= 1'b1;
               cnt      <= cnt + 1'b1;
               err_hold <= err_word;
            end
         end else if (!enb_n && !active) begin
            soc_err <= 1'b1;
         end
      end
   end

   AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_en));   // R4
   AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      active |=> $stable(sel_port));   // R4
   AST_SOC_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (port_soc & ~wr_en) == '0);   // R5
   AST_SOCERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      soc_err |-> wr_en == '0);   // R6
   AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (err_hold && !enb_n) |=> (port_err & wr_en) == wr_en);   // R8
endmodule

// File: rtl/cell_poll_slave.sv
module cell_poll_slave #(
   parameter int NPORTS      = 4,
   parameter int DW          = 32,
   parameter int CELL_WORDS  = 13,
   parameter int DIRECT_STAT = 0,
   parameter int CUSTOM_MAP  = 0,
   parameter logic [cps_pkg::MAX_PORTS*cps_pkg::ADDR_W-1:0] PORT_MAP = cps_pkg::descending_map()
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enb_n,
   input  logic [4:0]        addr,
   input  logic [DW-1:0]     data,
   input  logic              prty,
   input  logic              soc_in,
   input  logic [NPORTS-1:0] room,
   output logic [3:0]        clav,
   output logic [NPORTS-1:0] wr_en,
   output logic [DW-1:0]     port_data,
   output logic [NPORTS-1:0] port_soc,
   output logic [NPORTS-1:0] port_err,
   output logic              soc_err,
   output logic              prty_err
);
   import cps_pkg::*;

   localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

   if (NPORTS < 1 || NPORTS > MAX_PORTS) begin : g_bad_ports
      $error("cell_poll_slave: NPORTS out of range");
   end
   if (DIRECT_STAT != 0 && NPORTS > CLAV_W) begin : g_bad_direct
      $error("cell_poll_slave: direct status needs four ports or fewer");
   end
   if (CELL_WORDS < 1 || DW < 1) begin : g_bad_size
      $error("cell_poll_slave: CELL_WORDS and DW must be positive");
   end

   logic [ADDR_W-1:0] addr_q;
   logic              map_hit, bad_now;
   logic [PW-1:0]     map_port;

   always_ff @(posedge clk) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= addr;
   end

   cps_addr_map #(
      .NPORTS(NPORTS), .CUSTOM_MAP(CUSTOM_MAP), .PORT_MAP(PORT_MAP), .PW(PW)
   ) u_map (
      .addr(addr_q), .hit(map_hit), .port(map_port)
   );

   cps_status #(
      .NPORTS(NPORTS), .DIRECT_STAT(DIRECT_STAT), .PW(PW)
   ) u_status (
      .clk(clk), .rst_n(rst_n), .hit(map_hit), .port(map_port),
      .room(room), .clav(clav)
   );

   cps_parity #(.DW(DW)) u_par (
      .clk(clk), .rst_n(rst_n), .enb_n(enb_n), .data(data), .prty(prty),
      .bad_now(bad_now), .prty_err(prty_err)
   );

   cps_xfer #(
      .NPORTS(NPORTS), .DW(DW), .CELL_WORDS(CELL_WORDS), .PW(PW)
   ) u_xfer (
      .clk(clk), .rst_n(rst_n), .enb_n(enb_n), .soc_in(soc_in), .data(data),
      .map_hit(map_hit), .map_port(map_port), .bad_now(bad_now),
      .wr_en(wr_en), .port_soc(port_soc), .port_err(port_err),
      .port_data(port_data), .soc_err(soc_err)
   );
endmodule

// File: tb/sim_cell_poll_slave.sv
module sim_cell_poll_slave;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;

   // instance u0: four ports, direct addresses, polled status, 32-bit, 13 words
   logic        rst_n = 1'b0;
   logic        enb_n = 1'b1;
   logic [4:0]  addr = '0;
   logic [31:0] data = '0;
   logic        prty = 1'b1;
   logic        soc_in = 1'b0;
   logic [3:0]  room = '0;
   logic [3:0]  clav, wr_en, port_soc, port_err;
   logic [31:0] port_data;
   logic        soc_err, prty_err;

   cell_poll_slave #(
      .NPORTS(4), .DW(32), .CELL_WORDS(13), .DIRECT_STAT(0), .CUSTOM_MAP(0)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .enb_n(enb_n), .addr(addr), .data(data),
      .prty(prty), .soc_in(soc_in), .room(room), .clav(clav), .wr_en(wr_en),
      .port_data(port_data), .port_soc(port_soc), .port_err(port_err),
      .soc_err(soc_err), .prty_err(prty_err)
   );

   // instance u1: three ports, custom table (5,17,9), direct status, 16-bit, 4 words
   logic        enb1_n = 1'b1;
   logic [4:0]  addr1 = '0;
   logic [15:0] data1 = '0;
   logic        prty1 = 1'b1;
   logic        soc1 = 1'b0;
   logic [2:0]  room1 = '0;
   logic [3:0]  clav1;
   logic [2:0]  wr1, soc_o1, err_o1;
   logic [15:0] pdata1;
   logic        socerr1, perr1;

   cell_poll_slave #(
      .NPORTS(3), .DW(16), .CELL_WORDS(4), .DIRECT_STAT(1), .CUSTOM_MAP(1),
      .PORT_MAP(155'({5'd9, 5'd17, 5'd5}))
   ) u1 (
      .clk(clk), .rst_n(rst_n), .enb_n(enb1_n), .addr(addr1), .data(data1),
      .prty(prty1), .soc_in(soc1), .room(room1), .clav(clav1), .wr_en(wr1),
      .port_data(pdata1), .port_soc(soc_o1), .port_err(err_o1),
      .soc_err(socerr1), .prty_err(perr1)
   );

   // poll table: {address, room, expected clav[0]}
   localparam int NPOLL = 8;
   localparam logic [9:0] POLL_TAB [NPOLL] = '{
      {5'd0,  4'b0001, 1'b1},
      {5'd1,  4'b0001, 1'b0},
      {5'd1,  4'b0010, 1'b1},
      {5'd3,  4'b1000, 1'b1},
      {5'd2,  4'b1011, 1'b0},
      {5'd4,  4'b1111, 1'b0},
      {5'd31, 4'b1111, 1'b0},
      {5'd2,  4'b0100, 1'b1}
   };

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   // one cell on u0; leaves enb_n low at the end
   task automatic run_cell(input logic [4:0] a, input int bad, input int pause_at, input bit fresh);
      logic [3:0]  oh;
      logic [31:0] d;
      oh = 4'b0001 << a;
      if (fresh) begin
         @(negedge clk); enb_n = 1'b1; soc_in = 1'b0; addr = a;
         @(posedge clk);
      end
      for (int w = 0; w < 13; w++) begin
         if (w == pause_at) begin
            @(negedge clk); enb_n = 1'b1; soc_in = 1'b0; addr = a ^ 5'd1;
            @(posedge clk); #2;
            chk("R9 pause writes nothing", 64'(wr_en), 64'(0));
         end
         d = 32'hA500_0000 | (32'(a) << 16) | 32'(w);
         @(negedge clk);
         enb_n = 1'b0; soc_in = (w == 0); addr = a ^ 5'd1; data = d;
         prty = (~^d) ^ (w == bad);
         @(posedge clk); #2;
         chk("R4 R5 strobe on latched port", 64'(wr_en), 64'(oh));
         chk("R5 start-of-cell qualifier", 64'(port_soc), 64'((w == 0) ? oh : 4'b0));
         chk("R5 forwarded word", 64'(port_data), 64'(d));
         chk("R7 parity pulse", 64'(prty_err), 64'(w == bad));
         chk("R8 held error qualifier", 64'(port_err),
             64'((bad >= 0 && w >= bad) ? oh : 4'b0));
         chk("R6 no start error", 64'(soc_err), 64'(0));
      end
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
   end

   initial begin
      // R10: reset state
      repeat (3) @(posedge clk);
      #2;
      chk("R10 clav in reset", 64'(clav), 64'(0));
      chk("R10 strobes in reset", 64'({wr_en, port_soc, port_err}), 64'(0));
      chk("R10 pulses in reset", 64'({soc_err, prty_err}), 64'(0));
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #2;
      chk("R10 quiet after reset", 64'({clav, wr_en, soc_err, prty_err}), 64'(0));

      // R1 R3: poll table, address replaced by an unmatched one a cycle later
      for (int k = 0; k < NPOLL; k++) begin
         @(negedge clk); addr = POLL_TAB[k][9:5]; room = POLL_TAB[k][4:1];
         @(posedge clk);
         @(negedge clk); addr = 5'd20;
         @(posedge clk); #2;
         chk("R1 clav two cycles after address", 64'(clav[0]), 64'(POLL_TAB[k][0]));
         chk("R1 upper clav bits idle", 64'(clav[3:1]), 64'(0));
      end

      // R5: clean cell on port 0
      run_cell(5'd0, -1, -1, 1'b1);
      // R7 R8: parity fault at word 5 on port 3
      run_cell(5'd3, 5, -1, 1'b1);
      // R4 R8: back-to-back cell, same port, qualifier clear again
      run_cell(5'd3, -1, -1, 1'b0);
      // R9: pause before word 6 on port 1
      run_cell(5'd1, -1, 6, 1'b1);
      // R7 R8: fault on the final word
      run_cell(5'd2, 12, -1, 1'b1);

      // R6: cell opened without its marker, then a proper start
      @(negedge clk); enb_n = 1'b1; soc_in = 1'b0; addr = 5'd2;
      @(posedge clk);
      @(negedge clk); enb_n = 1'b0; soc_in = 1'b0; addr = 5'd0; data = 32'h0; prty = 1'b1;
      @(posedge clk); #2;
      chk("R6 start error pulse", 64'(soc_err), 64'(1));
      chk("R6 dropped word", 64'(wr_en), 64'(0));
      run_cell(5'd2, -1, -1, 1'b0);

      // R10: reset inside a cell, then a full cell from scratch
      @(negedge clk); enb_n = 1'b1; addr = 5'd1;
      @(posedge clk);
      for (int w = 0; w < 3; w++) begin
         @(negedge clk); enb_n = 1'b0; soc_in = (w == 0); data = 32'(w); prty = ~^(32'(w));
         @(posedge clk);
      end
      @(negedge clk); rst_n = 1'b0;
      @(posedge clk); #2;
      chk("R10 reset clears strobe", 64'(wr_en), 64'(0));
      @(negedge clk); rst_n = 1'b1; enb_n = 1'b1;
      run_cell(5'd1, -1, -1, 1'b1);
      @(negedge clk); enb_n = 1'b1;

      // R2: direct status lines on u1
      @(negedge clk); room1 = 3'b101; addr1 = 5'd17;
      @(posedge clk); #2;
      chk("R2 direct status pattern a", 64'(clav1), 64'(4'b0101));
      @(negedge clk); room1 = 3'b010; addr1 = 5'd3;
      @(posedge clk); #2;
      chk("R2 direct status pattern b", 64'(clav1), 64'(4'b0010));

      // R3: custom table, address 17 is port 1
      @(negedge clk); enb1_n = 1'b1; addr1 = 5'd17;
      @(posedge clk);
      for (int w = 0; w < 4; w++) begin
         @(negedge clk); enb1_n = 1'b0; soc1 = (w == 0); addr1 = 5'd5;
         data1 = 16'h3C00 | 16'(w); prty1 = ~^(16'h3C00 | 16'(w));
         @(posedge clk); #2;
         chk("R3 custom address selects port 1", 64'(wr1), 64'(3'b010));
         chk("R3 custom cell data", 64'(pdata1), 64'(16'h3C00 | 16'(w)));
      end
      // R3: address 1 matches nothing in the table
      @(negedge clk); enb1_n = 1'b1; addr1 = 5'd1;
      @(posedge clk);
      for (int w = 0; w < 4; w++) begin
         @(negedge clk); enb1_n = 1'b0; soc1 = (w == 0); data1 = 16'h0; prty1 = 1'b1;
         @(posedge clk); #2;
         chk("R3 unmatched address writes nothing", 64'(wr1), 64'(0));
      end
      // R3: address 5 is port 0
      @(negedge clk); enb1_n = 1'b1; addr1 = 5'd5;
      @(posedge clk);
      @(negedge clk); enb1_n = 1'b0; soc1 = 1'b1; data1 = 16'h0; prty1 = 1'b1;
      @(posedge clk); #2;
      chk("R3 custom address selects port 0", 64'({wr1, soc_o1}), 64'({3'b001, 3'b001}));
      @(negedge clk); enb1_n = 1'b1; soc1 = 1'b0;

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule